// File: doc/BRIEF.md
# Byte-Wide Serial Port Controller with Collision Guard

This block is a serial peripheral controller that hangs off a small processor register bus. It moves one byte at a time over a three-wire link: serial data in, serial data out, and a serial clock. In master mode, a processor write to the data register loads the byte and starts a full-duplex exchange. The serial clock is made from an external tick strobe, one tick for each clock half-period. In slave mode, the same shifter follows a serial clock that arrives on a pin. The status register has a completion flag and a collision flag.

A write to the data register is refused while a byte is moving. It is also refused while a finished byte has not been acknowledged. A refused write leaves the transfer and the received byte untouched and raises the collision flag. Both flags are cleared by one sequence: read the status register while the completion flag is set, then access the data register (read or write). When that access is a write, it also starts the next byte. The three pins are shared with general-purpose port bits. While the controller is disabled, they behave as plain port pins and the data register is plain storage.

All bus accesses are single-cycle strobes with no back-pressure. The bus never stalls. Instead of stalling, the controller drops an ill-timed data write and reports it through the collision flag. Read data on `bus_rdata` is combinational from `bus_addr`. The read side effects happen on the clock edge where `bus_sel` and `bus_rd` are both high.

Top module: `spi_port_ctrl`

## Requirements
- R1: Register map at `bus_addr`: 0 control (bit0 enable, bit1 master; reads back, resets to 0), 1 status (read-only: bit7 completion, bit6 collision, other bits 0), 2 data, 3 port latch (bits 2:0), 4 port direction (bits 2:0). Unused bits and addresses read 0.
- R2: In master mode with no transfer and no pending completion, a data write starts an 8-bit exchange, MSB first. SCK idles low and toggles once per tick, giving 16 ticks per byte. SDO changes after each falling SCK edge, and SDI is sampled at the rising edge. The received byte replaces the data register's read value.
- R3: The completion flag (status bit7) sets when the eighth bit has been shifted.
- R4: A data write while a byte is shifting has no effect on that transfer or on the received byte, and it sets the collision flag (status bit6).
- R5: A data write while the completion flag is set, before a status read, starts nothing, leaves the received byte readable, and sets the collision flag.
- R6: A status read while the completion flag is set, followed by a read or write of the data register, clears both flags. If that access is a write in master mode, it starts a new transfer.
- R7: A data read during shifting returns the last completed received byte.
- R8: With enable at 0, the data register is ordinary read/write storage. Each pin's output enable follows its direction bit, and each pin's output value follows its latch bit.
- R9: With enable at 1: pin 0 is the serial input (output enable 0); pin 1 drives SDO (output enable 1); pin 2 carries SCK, driven in master mode and an input (output enable 0) in slave mode.
- R10: A port read returns, per bit, the latch bit when its direction bit is 1 and the pin level when it is 0, whether or not the controller is enabled.
- R11: Reset clears control, flags, latch and direction, but the data register keeps its contents.
- R12: In slave mode, a data write loads the byte to send. The shifter clocks on the SCK pin, with the same edge roles as master mode, and the completion flag sets after the eighth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | SCK half-period strobe for master mode |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 3 | Pin levels: 0 serial in, 1 serial out, 2 SCK |
| pin_out | output | 3 | Pin output values |
| pin_oe | output | 3 | Pin output enables |

## Verification
The bench targets data writes that land mid-transfer, and writes that land after completion but before the status read. A design that let either write through would corrupt the byte seen on SDO, or overwrite the received byte. A design that failed to flag it would leave the collision bit low. The bench also alternates the two ways of clearing the flags. A design that counted only reads as the acknowledge would leave the flags stuck, or would not start the next byte. It also checks the data register across reset, and the direction-dependent port read with the controller on. A design that reset the data register, or that let the direction bits drive the pins while enabled, would read back the wrong value.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int PW = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_DATA = 3'd2;
  localparam logic [AW-1:0] A_PORT = 3'd3;
  localparam logic [AW-1:0] A_DIR  = 3'd4;

  localparam int CT_EN   = 0;
  localparam int CT_MS   = 1;
  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;

  localparam int PIN_SDI = 0;
  localparam int PIN_SDO = 1;
  localparam int PIN_SCK = 2;
endpackage

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         sck_pin,
  input  logic         sdi_pin,
  output logic         busy,
  output logic         sck_out,
  output logic         sdo,
  output logic         done_evt,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] bcnt;
  logic          samp, sck_q, busy_q;
  logic          sck_s, sck_d, sdi_s;
  logic          rise, fall, last;

  always_comb begin
    if (master) begin
      rise = en && tick && busy_q && !sck_q;
      fall = en && tick && busy_q && sck_q;
    end else begin
      rise = en && sck_s && !sck_d;
      fall = en && !sck_s && sck_d && busy_q;
    end
  end

  assign last     = (bcnt == LAST);
  assign done_evt = fall && last;
  assign rx_byte  = {sreg[W-2:0], samp};
  assign busy     = busy_q;
  assign sck_out  = sck_q;
  assign sdo      = sreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0; bcnt <= '0; samp <= 1'b0; sck_q <= 1'b0; busy_q <= 1'b0;
      sck_s <= 1'b0; sck_d <= 1'b0; sdi_s <= 1'b0;
    end else begin
      sck_s <= sck_pin;
      sck_d <= sck_s;
      sdi_s <= sdi_pin;
      if (!en) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        bcnt   <= '0;
      end else begin
        if (load) begin
          sreg <= load_byte;
          if (master) busy_q <= 1'b1;
        end
        if (rise) begin
          samp <= sdi_s;
          if (master) sck_q <= 1'b1;
          else        busy_q <= 1'b1;
        end
        if (fall) begin
          sreg <= {sreg[W-2:0], samp};
          bcnt <= bcnt + 1'b1;
          if (master) sck_q <= 1'b0;
          if (last)   busy_q <= 1'b0;
        end
      end
    end
  end

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) load |-> !busy_q);
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !sck_q);
  // R3
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> !busy_q);
  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && busy_q && !fall) |=> $stable(sreg));
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_port_pkg::*;
(
  input  logic          en,
  input  logic          master,
  input  logic [PW-1:0] latch,
  input  logic [PW-1:0] dir,
  input  logic [PW-1:0] pin_in,
  input  logic          sdo,
  input  logic          sck,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe,
  output logic [PW-1:0] port_rd
);
  for (genvar i = 0; i < PW; i++) begin : g_rd
    assign port_rd[i] = dir[i] ? latch[i] : pin_in[i];
  end

  always_comb begin
    pin_out = latch;
    pin_oe  = dir;
    if (en) begin
      pin_out[PIN_SDO] = sdo;
      pin_out[PIN_SCK] = sck;
      pin_oe[PIN_SDI]  = 1'b0;
      pin_oe[PIN_SDO]  = 1'b1;
      pin_oe[PIN_SCK]  = master;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe
);
  logic          en_q, ms_q, done_q, coll_q, armed_q;
  logic [PW-1:0] latch_q, dir_q, port_rd;
  logic [DW-1:0] dreg, rx_byte;
  logic          busy, sck, sdo, done_evt;
  logic          wr_data, rd_data, rd_stat, blocked, load, clr;

  assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_sel && bus_rd && (bus_addr == A_DATA);
  assign rd_stat = bus_sel && bus_rd && (bus_addr == A_STAT);
  assign blocked = busy || (done_q && !armed_q);
  assign load    = en_q && wr_data && !blocked;
  assign clr     = armed_q && (rd_data || wr_data);

  spi_shift_core #(.W(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en_q), .master(ms_q), .tick(tick),
    .load(load), .load_byte(bus_wdata),
    .sck_pin(pin_in[PIN_SCK]), .sdi_pin(pin_in[PIN_SDI]),
    .busy(busy), .sck_out(sck), .sdo(sdo), .done_evt(done_evt), .rx_byte(rx_byte)
  );

  spi_pin_mux u_mux (
    .en(en_q), .master(ms_q), .latch(latch_q), .dir(dir_q), .pin_in(pin_in),
    .sdo(sdo), .sck(sck), .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ms_q <= 1'b0; done_q <= 1'b0; coll_q <= 1'b0; armed_q <= 1'b0;
      latch_q <= '0; dir_q <= '0;
    end else begin
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          A_CTRL: begin en_q <= bus_wdata[CT_EN]; ms_q <= bus_wdata[CT_MS]; end
          A_PORT: latch_q <= bus_wdata[PW-1:0];
          A_DIR:  dir_q   <= bus_wdata[PW-1:0];
          default: ;
        endcase
      end
      if (clr) begin
        done_q <= 1'b0; coll_q <= 1'b0; armed_q <= 1'b0;
      end
      if (rd_stat && done_q) armed_q <= 1'b1;
      if (en_q && wr_data && blocked) coll_q <= 1'b1;
      if (done_evt) begin
        done_q <= 1'b1; armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!en_q && wr_data) dreg <= bus_wdata;
    else if (done_evt)    dreg <= rx_byte;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin bus_rdata[CT_EN] = en_q; bus_rdata[CT_MS] = ms_q; end
      A_STAT: begin bus_rdata[ST_DONE] = done_q; bus_rdata[ST_COLL] = coll_q; end
      A_DATA: bus_rdata = dreg;
      A_PORT: bus_rdata[PW-1:0] = port_rd;
      A_DIR:  bus_rdata[PW-1:0] = dir_q;
      default: ;
    endcase
  end

  // R5
  coll_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(coll_q) |-> $past(wr_data));
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(rd_data || wr_data));
  // R4
  data_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_data && blocked && !done_evt) |=> $stable(dreg));
  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> done_q);
endmodule

// File: tb/spi_port_ctrl_bench.sv
module spi_port_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in, pin_out, pin_oe;

  logic       sck_drv = 1'b0, gp1 = 1'b0, man_sdi = 1'b0, model_on = 1'b0;
  logic [7:0] next_slave = '0, mosi_cap = '0;
  logic [2:0] fc = '0;
  logic       prev_sck = 1'b0;
  logic [1:0] tcnt = '0;
  int         total = 0, bad = 0;
  logic       finished = 1'b0;

  assign pin_in = {sck_drv, gp1, model_on ? next_slave[3'd7 - fc] : man_sdi};

  spi_port_ctrl u_spi_port_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
    prev_sck <= pin_out[2];
    if (model_on) begin
      if (pin_out[2] && !prev_sck) mosi_cap <= {mosi_cap[6:0], pin_out[1]};
      if (!pin_out[2] && prev_sck) fc <= fc + 3'd1;
    end
  end

  function automatic logic [7:0] exp_stat(input logic d, input logic c);
    return {d, c, 6'b0};
  endfunction
  function automatic logic [2:0] exp_port(input logic [2:0] d, input logic [2:0] l, input logic [2:0] p);
    return (d & l) | (~d & p);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, tx, prev_rx;
    logic coll_exp, started;
    void'($urandom(32'd1234));
    pulse_reset();
    bread(3'd0, rd); check("R11 ctrl reset", rd, 8'h00);
    bread(3'd1, rd); check("R11 stat reset", rd, 8'h00);
    check("R8 oe reset", {5'b0, pin_oe}, 8'h00);
    bread(3'd5, rd); check("R1 unused addr", rd, 8'h00);

    // R8 storage, R11 retention
    bwrite(3'd2, 8'h5A);
    bread(3'd2, rd); check("R8 storage", rd, 8'h5A);
    pulse_reset();
    bread(3'd2, rd); check("R11 data kept", rd, 8'h5A);

    // R8 / R10 general-purpose pins
    bwrite(3'd4, 8'h05); bwrite(3'd3, 8'h03);
    sck_drv = 1; gp1 = 1; man_sdi = 0;
    @(negedge clk);
    check("R8 oe", {5'b0, pin_oe}, 8'h05);
    check("R8 out", {5'b0, pin_out}, 8'h03);
    bread(3'd3, rd); check("R10 port read", rd, 8'h03);
    for (int i = 0; i < 6; i++) begin
      logic [2:0] d, l, p;
      d = 3'($urandom); l = {1'b0, 2'($urandom)}; p = 3'($urandom);
      bwrite(3'd4, {5'b0, d}); bwrite(3'd3, {5'b0, l});
      {sck_drv, gp1, man_sdi} = p;
      bread(3'd3, rd); check("R10 random port", rd, {5'b0, exp_port(d, l, p)});
      check("R8 random oe", {5'b0, pin_oe}, {5'b0, d});
    end
    sck_drv = 0; gp1 = 0; man_sdi = 0;
    bwrite(3'd3, 8'h00); bwrite(3'd4, 8'h07);

    // R9 master pin roles
    bwrite(3'd0, 8'h03);
    @(negedge clk);
    check("R9 master oe", {5'b0, pin_oe}, 8'h06);
    check("R9 sck idle", {7'b0, pin_out[2]}, 8'h00);
    gp1 = 1;
    bread(3'd3, rd); check("R10 port read enabled", rd, 8'h00);
    bwrite(3'd4, 8'h00);
    bread(3'd3, rd); check("R10 pin read enabled", rd, 8'h02);
    gp1 = 0;
    bread(3'd0, rd); check("R1 ctrl readback", rd, 8'h03);

    model_on = 1;
    prev_rx = 8'h5A;
    started = 0;
    tx = 8'h00;
    for (int i = 0; i < 16; i++) begin
      if (!started) begin
        tx = 8'($urandom); next_slave = 8'($urandom);
        bwrite(3'd2, tx);
      end
      repeat (20) @(negedge clk);
      bread(3'd2, rd); check("R7 read during shift", rd, prev_rx);
      coll_exp = (i % 3 == 0);
      if (coll_exp) bwrite(3'd2, ~tx);  // R4
      repeat (90) @(negedge clk);
      check("R2 mosi MSB first", mosi_cap, tx);
      if (i % 4 == 1) begin
        bwrite(3'd2, 8'h00);  // R5 blocked
        coll_exp = 1;
        repeat (30) @(negedge clk);
        check("R5 no restart", mosi_cap, tx);
      end
      bread(3'd2, rd); check("R2 received byte", rd, next_slave);
      prev_rx = next_slave;
      bread(3'd1, rd); check("R3 R4 status", rd, exp_stat(1'b1, coll_exp));
      if (i % 2 == 0 || i == 15) begin
        bread(3'd2, rd);
        started = 0;
      end else begin
        tx = 8'($urandom); next_slave = 8'($urandom);
        bwrite(3'd2, tx);
        started = 1;
      end
      bread(3'd1, rd); check("R6 flags cleared", rd, 8'h00);
    end
    model_on = 0;

    // R12 slave mode
    bwrite(3'd0, 8'h01);
    @(negedge clk);
    check("R9 slave oe", {5'b0, pin_oe}, 8'h02);
    bwrite(3'd2, 8'hC3);
    begin
      logic [7:0] sb, cap;
      sb = 8'h96; cap = '0;
      for (int b = 7; b >= 0; b--) begin
        man_sdi = sb[b];
        repeat (3) @(negedge clk);
        sck_drv = 1;
        cap = {cap[6:0], pin_out[1]};
        repeat (4) @(negedge clk);
        sck_drv = 0;
        repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check("R12 slave sdo", cap, 8'hC3);
      bread(3'd1, rd); check("R12 slave done", rd, exp_stat(1'b1, 1'b0));
      bread(3'd2, rd); check("R12 slave rx", rd, sb);
      bread(3'd1, rd); check("R6 slave clear", rd, 8'h00);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule